// File: doc/BRIEF.md
# Ping-Pong Single-Port Delay Line

This block is a fixed-length delay line for the feedback path of a pipelined FFT stage. Each cycle in which the input is marked valid, it accepts one complex word and returns the word that was accepted exactly L valid cycles earlier. Cycles without a valid input do not count toward the delay, so the block behaves like a first-in first-out queue of constant occupancy L that advances only on valid data.

The storage is split into two single-port banks of L/2 words each, instead of one dual-port memory of L words. Consecutive valid words go to alternate banks. In every valid cycle one bank is written while the other is read, so no bank ever needs a read and a write in the same cycle. Both banks share one sequential address counter, because the delay line needs no random access. The word read from the idle bank is held in the bank's output register and is moved to the block output on the next valid cycle, which keeps the latency constant. The word width is a parameter sized to carry the I and Q parts together with any bit growth of the pipeline.

Top module: `pp_delay_line`

## Requirements
- R1: While reset is held, and for the first L valid inputs after reset is released, outValid stays low.
- R2: For valid input number k (counting from 0 after reset) with k >= L, outValid is high after the next rising clock edge, and outData then equals the word that was accepted with valid input number k-L.
- R3: After a clock edge that sampled inValid low, outValid is low and outData keeps its previous value. That cycle does not count toward the delay of L valid inputs.
- R4: In each valid cycle, exactly one bank is written and the other bank is read. No bank is accessed in a cycle without a valid input.
- R5: The bank that is written alternates on every valid cycle, starting with bank 0 after reset. The bank selection holds its value through cycles without a valid input.
- R6: The shared bank address stays in the range 0 to L/2-1. It advances by one, with wrap-around, after every second valid input.
- R7: A reset asserted part way through a stream discards the stored history. After the reset is released, L new valid inputs are needed again before outValid rises.
- R8: The behaviour of R1 to R3 holds at the smallest allowed delay, L = 4, where each bank holds two words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Marks inData as a valid word in this cycle |
| inData | input | DATA_W | Complex input word (I and Q together) |
| outValid | output | 1 | Marks outData as a delayed word |
| outData | output | DATA_W | Word accepted L valid inputs earlier |

## Verification
The assertions assume that L is even and at least 4, and that inValid is a defined level on every clock edge once reset has been released. They make no assumption about the input data or about how valid and idle cycles alternate. The stimulus holds inValid at a defined level from time zero and drives it only away from the active edge. It mixes random valid and idle patterns, with idle density that varies from none to long gaps, so that the bank selection and the address wrap meet idle cycles at every phase. A reset in the middle of a stream checks that the fill count starts again.

// File: rtl/pp_delay_pkg.sv
package pp_delay_pkg;

  // Strobes from the control to the datapath, one set per clock cycle.
  typedef struct packed {
    logic [1:0] bankEn;   // bank i takes part in an access this cycle
    logic [1:0] bankWe;   // bank i access is a write (else a read)
    logic       srcBank;  // bank whose held read word feeds the output
    logic       loadOut;  // move the held read word to the output register
    logic       validNow; // the word being loaded is a real delayed word
  } ppStrobe_t;

endpackage

// File: rtl/pp_delay_bank.sv
module pp_delay_bank #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdData
);

  logic [W-1:0] mem [DEPTH];

  // One address port: each enabled cycle is either a write or a read.
  // The read register keeps its value until the next read.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wrData;
      end else begin
        rdData <= mem[addr];
      end
    end
  end

endmodule

// File: rtl/pp_delay_ctrl.sv
module pp_delay_ctrl
  import pp_delay_pkg::*;
#(
  parameter int DELAY = 16,
  localparam int DEPTH = DELAY / 2,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW    = $clog2(DELAY + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output ppStrobe_t     strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);

  localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);
  localparam logic [FW-1:0] FILL_MAX  = FW'(DELAY);

  logic          sel;      // bank written in this valid cycle
  logic [AW-1:0] addrCnt;  // shared word address of the current pair
  logic [AW-1:0] addrNext;
  logic [FW-1:0] fillCnt;  // valid inputs seen since reset, saturating
  logic          primed;

  assign addrNext = (addrCnt == ADDR_LAST) ? '0 : addrCnt + 1'b1;
  assign primed   = (fillCnt == FILL_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sel     <= 1'b0;
      addrCnt <= '0;
      fillCnt <= '0;
    end else if (inValid) begin
      sel <= ~sel;
      if (sel) begin
        addrCnt <= addrNext;
      end
      if (!primed) begin
        fillCnt <= fillCnt + 1'b1;
      end
    end
  end

  // The write of the current word goes to bank sel at the current pair
  // address. The other bank is read for the word needed by the next valid
  // cycle; it sits in the pair after the current one when sel is 1.
  assign wrAddr = addrCnt;
  assign rdAddr = sel ? addrNext : addrCnt;

  always_comb begin
    strobe.bankEn   = inValid ? 2'b11 : 2'b00;
    strobe.bankWe   = inValid ? (sel ? 2'b10 : 2'b01) : 2'b00;
    strobe.srcBank  = sel;
    strobe.loadOut  = inValid;
    strobe.validNow = inValid && primed;
  end

  // R5
  bank_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (sel == ~$past(sel)));

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(sel) && $stable(addrCnt) && $stable(fillCnt)));

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrCnt <= ADDR_LAST) && (rdAddr <= ADDR_LAST));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !sel) |=> $stable(addrCnt));

endmodule

// File: rtl/pp_delay_dpath.sv
module pp_delay_dpath
  import pp_delay_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  ppStrobe_t     strobe,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [W-1:0]  inData,
  output logic          outValid,
  output logic [W-1:0]  outData
);

  logic [W-1:0] bankRd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [AW-1:0] bankAddr;
    assign bankAddr = strobe.bankWe[b] ? wrAddr : rdAddr;

    pp_delay_bank #(
      .W     (W),
      .DEPTH (DEPTH)
    ) bank_i (
      .clk    (clk),
      .en     (strobe.bankEn[b]),
      .we     (strobe.bankWe[b]),
      .addr   (bankAddr),
      .wrData (inData),
      .rdData (bankRd[b])
    );
  end

  // The word read in the previous valid cycle sits in the register of the
  // bank that is being written now, since a write leaves that register alone.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobe.validNow;
      if (strobe.loadOut) begin
        outData <= bankRd[strobe.srcBank];
      end
    end
  end

  // R4
  bank_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |-> ((strobe.bankEn == 2'b11) && $onehot0(strobe.bankWe)
                        && ($countones(strobe.bankWe) == 1)));

  // R4
  bank_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadOut |-> ((strobe.bankEn == 2'b00) && (strobe.bankWe == 2'b00)));

  // R3
  idle_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadOut |=> (!outValid && $stable(outData)));

  // R2
  out_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe.loadOut));

endmodule

// File: rtl/pp_delay_line.sv
module pp_delay_line
  import pp_delay_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DELAY  = 16,
  localparam int DEPTH = DELAY / 2,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  ppStrobe_t     strobe;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  pp_delay_ctrl #(
    .DELAY (DELAY)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr)
  );

  pp_delay_dpath #(
    .W     (DATA_W),
    .DEPTH (DEPTH)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData)
  );

endmodule

// File: tb/pp_delay_line_tb.sv
module pp_delay_line_tb_top;

  localparam int LA = 16;   // delay of the main instance
  localparam int LB = 4;    // smallest delay, second instance
  localparam int HN = 8192;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        outValidA;
  logic [31:0] outDataA;
  logic        outValidB;
  logic [7:0]  outDataB;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] hist [HN];
  int          vcount = 0;
  logic [31:0] prevA = '0;
  logic [7:0]  prevB = '0;

  always #10 clk = ~clk;   // 20 ns period

  pp_delay_line #(.DATA_W(32), .DELAY(LA)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValidA), .outData(outDataA)
  );

  pp_delay_line #(.DATA_W(8), .DELAY(LB)) dut_min_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData[7:0]),
    .outValid(outValidB), .outData(outDataB)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit expValid(input int n, input int lat);
    return n >= lat;
  endfunction

  function automatic logic [31:0] expWord(input int n, input int lat);
    return hist[(n - lat) % HN];
  endfunction

  // Drive one cycle at the falling edge, then check after the next falling edge.
  task automatic step(input bit v, input logic [31:0] d, input string tag);
    inValid = v;
    inData  = d;
    @(posedge clk);
    @(negedge clk);
    if (v) begin
      bit ea = expValid(vcount, LA);
      bit eb = expValid(vcount, LB);
      chk(outValidA == ea, ea ? "R2" : tag, "outValid", outValidA, ea);
      chk(outValidB == eb, eb ? "R8 R2" : "R8 R1", "outValid min", outValidB, eb);
      if (ea) begin
        logic [31:0] w = expWord(vcount, LA);
        chk(outDataA == w, "R2 R4 R5 R6", "outData", outDataA, w);
      end
      if (eb) begin
        logic [7:0] w8 = expWord(vcount, LB)[7:0];
        chk(outDataB == w8, "R8 R2", "outData min", outDataB, w8);
      end
      hist[vcount % HN] = d;
      vcount++;
    end else begin
      chk(!outValidA, "R3", "outValid idle", outValidA, 0);
      chk(outDataA == prevA, "R3", "outData hold", outDataA, prevA);
      chk(!outValidB, "R8 R3", "outValid idle min", outValidB, 0);
      chk(outDataB == prevB, "R8 R3", "outData hold min", outDataB, prevB);
    end
    prevA = outDataA;
    prevB = outDataB;
  endtask

  task automatic doReset(input string tag);
    inValid = 1'b0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!outValidA && !outValidB, tag, "outValid in reset", outValidA, 0);
    rstN = 1'b1;
    vcount = 0;
    prevA = outDataA;
    prevB = outDataB;
  endtask

  initial begin
    void'($urandom(32'h5EED_0F1F));
    @(negedge clk);
    doReset("R1");

    // Directed: unbroken stream across several address wraps.
    for (int i = 0; i < 3 * LA + 3; i++) step(1'b1, $urandom, "R1");

    // Directed: alternating valid and idle, so idles fall on both bank phases.
    for (int i = 0; i < 40; i++) step(i % 2 == 0, $urandom, "R1");

    // Directed: long idle gap mid-stream, then resume.
    for (int i = 0; i < 25; i++) step(1'b0, $urandom, "R3");
    for (int i = 0; i < 2 * LA; i++) step(1'b1, $urandom, "R1");

    // Directed: reset part way through, history must be discarded.
    for (int i = 0; i < 7; i++) step(1'b1, $urandom, "R1");
    doReset("R7");
    for (int i = 0; i < LA + 4; i++) step(1'b1, $urandom, "R7");

    // Reset with idles mixed into the refill.
    doReset("R7");
    for (int i = 0; i < 3 * LA; i++) step(($urandom % 3) != 0, $urandom, "R7");

    // Random: varying idle density.
    for (int blk = 0; blk < 12; blk++) begin
      int pct = 10 + (blk * 8);
      for (int i = 0; i < 300; i++) begin
        step(($urandom % 100) >= pct, $urandom, "R1");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule